// File: doc/BRIEF.md
# Scatter-Gather Transmit Frame Length Gate

This block sits in a transmit path between the unit that fetches buffer descriptors and the MAC. A frame reaches it as a chain of segments. Each segment starts with a descriptor that gives a byte count and a flag marking the final segment of the frame. That segment's bytes then follow one per accepted beat. The gate collects every segment of the frame into an internal store and keeps a running byte total. When the final segment ends, it makes one keep-or-drop decision for the whole frame.

A frame whose total lies between 1 and `MAX_FRAME` bytes is released to the MAC as one unbroken burst. `MAX_FRAME` is 9600 by default. The total includes the 14-byte Ethernet header but not the 4-byte FCS, so the payload may be at most `MAX_FRAME - 14` bytes (9586 by default). A frame whose total is zero or above the limit never appears on the output. In both outcomes a single-cycle status pulse reports the result and the final byte total.

The control is a six-state machine:
- `ST_DESC` waits for a descriptor.
- `ST_BYTES` takes the segment's bytes.
- `ST_JUDGE` is a single decision cycle.
- `ST_SEND` plays the stored frame out.
- `ST_DONE` reports a frame that was sent.
- `ST_REJECT` reports a frame that was dropped.

The transitions are:
- `ST_DESC` goes to `ST_BYTES` on a non-empty descriptor.
- `ST_DESC` goes to `ST_JUDGE` on an empty descriptor marked final.
- `ST_DESC` stays put on an empty descriptor not marked final.
- `ST_BYTES` goes back to `ST_DESC` when a non-final segment's count runs out.
- `ST_BYTES` goes to `ST_JUDGE` when the final segment's count runs out.
- `ST_JUDGE` goes to `ST_SEND` when the length fits, and to `ST_REJECT` otherwise.
- `ST_SEND` goes to `ST_DONE` on the last byte out.
- `ST_DONE` and `ST_REJECT` both return to `ST_DESC`.

Top module: `sg_tx_len_gate`

## Requirements
- R1: After reset, `desc_ready` is 1 and `byte_ready`, `tx_valid` and `st_valid` are 0.
- R2: A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both 1. Exactly `desc_len` bytes are then taken, each on an edge where `byte_valid` and `byte_ready` are both 1. A descriptor with `desc_len` = 0 takes no bytes, and `desc_ready` is 1 again on the next cycle.
- R3: A frame that is kept appears on `tx_data` as the bytes of all its segments in arrival order, one byte per cycle with `tx_valid` held high. `tx_last` marks only the final byte. Nothing appears on the output while the frame's segments are still arriving.
- R4: The frame length is the sum of all segment byte counts, counted afresh from zero for every frame. A frame of length 1 to `MAX_FRAME` is forwarded and reported with `st_err` = 0 and `st_len` equal to that length.
- R5: A frame whose length exceeds `MAX_FRAME` puts no byte on the output, however many segments it is split into. It is reported with `st_err` = 1 and its length on `st_len`.
- R6: A frame of total length zero puts no byte on the output and is reported with `st_err` = 1 and `st_len` = 0.
- R7: `st_valid` is high for exactly one cycle per frame. For a forwarded frame it is high in the cycle right after the one carrying `tx_last`. For a dropped frame it comes one cycle after the edge that takes the frame's final byte or final empty descriptor. The first output byte of a forwarded frame appears with the same timing.
- R8: The length count is 16 bits wide and saturates at 65535, so `st_len` reports 65535 for any longer frame and that frame is dropped.
- R9: Neither `desc_ready` nor `byte_ready` is high in a cycle where `tx_valid` or `st_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Gate accepts a descriptor |
| desc_len | input | LEN_W | Segment byte count |
| desc_last | input | 1 | Segment ends the frame |
| byte_valid | input | 1 | Segment byte offered |
| byte_ready | output | 1 | Gate accepts a segment byte |
| byte_data | input | 8 | Segment byte |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte to MAC |
| tx_last | output | 1 | Final byte of the frame |
| st_valid | output | 1 | Status pulse |
| st_err | output | 1 | 1 = frame dropped (zero or too long) |
| st_len | output | LEN_W | Final frame byte total |

## Verification
Every cycle, the assertions check the following:
- The handshake-ready and output signals are mutually exclusive.
- An output burst has no holes and ends in a status pulse on the next cycle.
- The status pulse lasts one cycle.
- The error flag agrees with the reported length.
- An empty non-final descriptor returns straight to descriptor acceptance.

Only the bench's sweeps can show the following:
- The output bytes really are the segments joined in order.
- The reported total equals the sum over an arbitrary segmentation.
- An oversize frame split into many small segments never leaks a byte.
- Saturation holds past 65535.
- The one-cycle decision timing is met.

// File: rtl/sgtx_pkg.sv
package sgtx_pkg;

    typedef enum logic [2:0] {
        ST_DESC,
        ST_BYTES,
        ST_JUDGE,
        ST_SEND,
        ST_DONE,
        ST_REJECT
    } gate_state_e;

endpackage

// File: rtl/sgtx_len_acc.sv
module sgtx_len_acc #(
    parameter int MAX_FRAME = 9600,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] len,
    output logic             fits,
    output logic             room
);
    localparam logic [LEN_W-1:0] SAT   = '1;
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_FRAME);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len <= '0;
        end else if (clr) begin
            len <= '0;
        end else if (inc && len != SAT) begin
            len <= len + LEN_W'(1);
        end
    end

    assign fits = (len != '0) && (len <= LIMIT);
    assign room = (len < LIMIT);
endmodule

// File: rtl/sgtx_frame_store.sv
module sgtx_frame_store #(
    parameter int LANES  = 8,
    parameter int WORDS  = 1200,
    parameter int LANE_W = $clog2(LANES),
    parameter int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    parameter int POS_W  = LANE_W + ADDR_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [POS_W-1:0] wr_pos,
    input  logic [7:0]       wr_byte,
    input  logic [POS_W-1:0] rd_pos,
    output logic [7:0]       rd_byte
);
    logic [ADDR_W-1:0] wr_word, rd_word;
    logic [LANE_W-1:0] wr_lane, rd_lane;
    logic [7:0]        lane_q [LANES];

    assign wr_word = wr_pos[POS_W-1:LANE_W];
    assign wr_lane = wr_pos[LANE_W-1:0];
    assign rd_word = rd_pos[POS_W-1:LANE_W];
    assign rd_lane = rd_pos[LANE_W-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [WORDS];
        always_ff @(posedge clk) begin
            if (we && wr_lane == LANE_W'(g)) begin
                cells[wr_word] <= wr_byte;
            end
        end
        assign lane_q[g] = cells[rd_word];
    end

    assign rd_byte = lane_q[rd_lane];
endmodule

// File: rtl/sgtx_ctrl.sv
module sgtx_ctrl
    import sgtx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_last,
    input  logic             byte_valid,
    input  logic             len_fits,
    input  logic [LEN_W-1:0] frame_len,
    output logic             desc_ready,
    output logic             byte_ready,
    output logic             len_inc,
    output logic             len_clr,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             st_valid,
    output logic             st_err,
    output logic [LEN_W-1:0] rd_pos
);
    gate_state_e      state, nxt;
    logic [LEN_W-1:0] seg_rem;
    logic             seg_final;
    logic             end_of_send;

    assign end_of_send = (rd_pos == frame_len - LEN_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DESC;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_DESC: begin
                if (desc_valid) begin
                    if (desc_len != '0) nxt = ST_BYTES;
                    else if (desc_last) nxt = ST_JUDGE;
                end
            end
            ST_BYTES: begin
                if (byte_valid && seg_rem == LEN_W'(1)) begin
                    nxt = seg_final ? ST_JUDGE : ST_DESC;
                end
            end
            ST_JUDGE:  nxt = len_fits ? ST_SEND : ST_REJECT;
            ST_SEND:   if (end_of_send) nxt = ST_DONE;
            ST_DONE:   nxt = ST_DESC;
            ST_REJECT: nxt = ST_DESC;
            default:   nxt = ST_DESC;
        endcase
    end

    // segment and playback counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_rem   <= '0;
            seg_final <= 1'b0;
            rd_pos    <= '0;
        end else begin
            if (state == ST_DESC && desc_valid) begin
                seg_rem   <= desc_len;
                seg_final <= desc_last;
            end else if (state == ST_BYTES && byte_valid) begin
                seg_rem <= seg_rem - LEN_W'(1);
            end
            if (state == ST_JUDGE)     rd_pos <= '0;
            else if (state == ST_SEND) rd_pos <= rd_pos + LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        desc_ready = 1'b0;
        byte_ready = 1'b0;
        tx_valid   = 1'b0;
        tx_last    = 1'b0;
        st_valid   = 1'b0;
        st_err     = 1'b0;
        len_clr    = 1'b0;
        unique case (state)
            ST_DESC:  desc_ready = 1'b1;
            ST_BYTES: byte_ready = 1'b1;
            ST_JUDGE: ;
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = end_of_send;
            end
            ST_DONE: begin
                st_valid = 1'b1;
                len_clr  = 1'b1;
            end
            ST_REJECT: begin
                st_valid = 1'b1;
                st_err   = 1'b1;
                len_clr  = 1'b1;
            end
            default: ;
        endcase
        len_inc = byte_ready && byte_valid;
    end
endmodule

// File: rtl/sg_tx_len_gate.sv
module sg_tx_len_gate
    import sgtx_pkg::*;
#(
    parameter int MAX_FRAME = 9600,
    parameter int LEN_W     = 16,
    parameter int LANES     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_last,
    input  logic             byte_valid,
    output logic             byte_ready,
    input  logic [7:0]       byte_data,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             st_valid,
    output logic             st_err,
    output logic [LEN_W-1:0] st_len
);
    localparam int WORDS  = (MAX_FRAME + LANES - 1) / LANES;
    localparam int LANE_W = $clog2(LANES);
    localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int POS_W  = LANE_W + ADDR_W;

    logic [LEN_W-1:0] frame_len, rd_pos;
    logic             len_fits, len_room, len_inc, len_clr;

    sgtx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .desc_len   (desc_len),
        .desc_last  (desc_last),
        .byte_valid (byte_valid),
        .len_fits   (len_fits),
        .frame_len  (frame_len),
        .desc_ready (desc_ready),
        .byte_ready (byte_ready),
        .len_inc    (len_inc),
        .len_clr    (len_clr),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .st_valid   (st_valid),
        .st_err     (st_err),
        .rd_pos     (rd_pos)
    );

    sgtx_len_acc #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (len_clr),
        .inc   (len_inc),
        .len   (frame_len),
        .fits  (len_fits),
        .room  (len_room)
    );

    sgtx_frame_store #(
        .LANES  (LANES),
        .WORDS  (WORDS),
        .LANE_W (LANE_W),
        .ADDR_W (ADDR_W),
        .POS_W  (POS_W)
    ) u_store (
        .clk     (clk),
        .we      (len_inc && len_room),
        .wr_pos  (frame_len[POS_W-1:0]),
        .wr_byte (byte_data),
        .rd_pos  (rd_pos[POS_W-1:0]),
        .rd_byte (tx_data)
    );

    assign st_len = frame_len;
endmodule

// File: rtl/sgtx_gate_chk.sv
module sgtx_gate_chk #(
    parameter int MAX_FRAME = 9600,
    parameter int LEN_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             desc_valid,
    input logic             desc_ready,
    input logic [LEN_W-1:0] desc_len,
    input logic             desc_last,
    input logic             byte_ready,
    input logic             tx_valid,
    input logic             tx_last,
    input logic             st_valid,
    input logic             st_err,
    input logic [LEN_W-1:0] st_len
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_FRAME);

    // R9
    exclusive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_ready, byte_ready, tx_valid, st_valid}));

    // R3
    burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |=> tx_valid);

    // R7
    sent_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last) |=> (st_valid && !st_err));

    // R7
    status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);

    // R5
    drop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_err) |-> (st_len == '0 || st_len > LIMIT));

    // R4
    sent_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_err) |-> (st_len != '0 && st_len <= LIMIT));

    // R2
    empty_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready && desc_len == '0 && !desc_last) |=> desc_ready);
endmodule

bind sg_tx_len_gate sgtx_gate_chk #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_len   (desc_len),
    .desc_last  (desc_last),
    .byte_ready (byte_ready),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .st_valid   (st_valid),
    .st_err     (st_err),
    .st_len     (st_len)
);

// File: tb/sg_tx_len_gate_test.sv
`timescale 1ns/1ps
module sg_tx_len_gate_test;
    localparam int MAXF  = 40;
    localparam int LEN_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic desc_valid = 1'b0, desc_last = 1'b0, byte_valid = 1'b0;
    logic [LEN_W-1:0] desc_len = '0;
    logic [7:0] byte_data = '0;
    logic desc_ready, byte_ready, tx_valid, tx_last, st_valid, st_err;
    logic [7:0] tx_data;
    logic [LEN_W-1:0] st_len;

    int errors = 0, checks = 0, cyc = 0, acc_cyc = 0;
    int got_n = 0, first_tx_cyc = -1, last_tx_cyc = -1, st_cyc = -1;
    logic [7:0] got [128];
    logic st_seen = 1'b0, st_err_q = 1'b0, busy_viol = 1'b0, finished = 1'b0;
    int st_len_q = 0;

    always #2 clk = ~clk;

    sg_tx_len_gate #(.MAX_FRAME(MAXF), .LEN_W(LEN_W), .LANES(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_len(desc_len),
        .desc_last(desc_last), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .byte_data(byte_data), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .st_valid(st_valid), .st_err(st_err), .st_len(st_len)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                if (got_n < 128) got[got_n] = tx_data;
                if (first_tx_cyc < 0) first_tx_cyc = cyc;
                got_n = got_n + 1;
                if (tx_last) last_tx_cyc = cyc;
            end
            if (st_valid) begin
                st_seen  = 1'b1;
                st_err_q = st_err;
                st_len_q = int'(st_len);
                st_cyc   = cyc;
            end
            if ((tx_valid || st_valid) && (desc_ready || byte_ready)) busy_viol = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_desc(input int len, input bit last);
        desc_valid = 1'b1;
        desc_len   = LEN_W'(len);
        desc_last  = last;
        while (!desc_ready) @(negedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        acc_cyc = cyc;
        if (len == 0 && !last) begin
            // R2: empty non-final descriptor takes no bytes
            check(desc_ready && !byte_ready, "R2 empty segment", int'(byte_ready), 0);
        end
    endtask

    task automatic push_byte(input logic [7:0] d, input bit gap);
        if (gap) @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = d;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        acc_cyc = cyc;
    endtask

    function automatic logic [7:0] pat(input int fid, input int i);
        return 8'((fid * 7 + i * 13 + 5) & 255);
    endfunction

    task automatic run_frame(input int fid, input int total, input int seg,
                             input bit zmode, input bit gap);
        int rem, idx, n, exp_len;
        bit ok, data_ok;
        got_n = 0; first_tx_cyc = -1; last_tx_cyc = -1; st_cyc = -1;
        st_seen = 1'b0; busy_viol = 1'b0;
        rem = total; idx = 0;
        if (zmode) push_desc(0, 1'b0);
        while (rem > 0) begin
            n = (rem < seg) ? rem : seg;
            push_desc(n, (rem == n) && !zmode);
            for (int k = 0; k < n; k++) begin
                push_byte(pat(fid, idx), gap && (k % 3 == 1));
                idx++;
            end
            rem -= n;
        end
        if (total == 0 || zmode) push_desc(0, 1'b1);
        for (int w = 0; w < 200 && !st_seen; w++) @(negedge clk);
        @(negedge clk);
        exp_len = (total > 65535) ? 65535 : total;
        ok = (total >= 1) && (total <= MAXF);
        check(st_seen, "R7 status seen", int'(st_seen), 1);
        if (total == 0)
            check(st_err_q && st_len_q == 0, "R6 zero frame", st_len_q, 0);
        else if (!ok)
            check(st_err_q == 1'b1, "R5 oversize error", int'(st_err_q), 1);
        else
            check(st_err_q == 1'b0, "R4 sent flag", int'(st_err_q), 0);
        // R4 R8 length
        check(st_len_q == exp_len, "R4 R8 status length", st_len_q, exp_len);
        check(got_n == (ok ? total : 0), "R3 R5 output byte count", got_n, ok ? total : 0);
        data_ok = 1'b1;
        for (int i = 0; i < got_n && i < 128; i++) if (got[i] !== pat(fid, i)) data_ok = 1'b0;
        check(data_ok, "R3 output bytes", int'(data_ok), 1);
        if (ok) begin
            check(first_tx_cyc - acc_cyc == 1, "R7 first byte timing", first_tx_cyc - acc_cyc, 1);
            check(st_cyc - last_tx_cyc == 1, "R7 sent status timing", st_cyc - last_tx_cyc, 1);
        end else begin
            check(st_cyc - acc_cyc == 1, "R7 drop status timing", st_cyc - acc_cyc, 1);
        end
        check(!busy_viol, "R9 ready while busy", int'(busy_viol), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(desc_ready && !byte_ready && !tx_valid && !st_valid, "R1 reset outputs",
              int'({desc_ready, byte_ready, tx_valid, st_valid}), 8);
        begin
            int fid = 0;
            for (int t = 0; t <= MAXF + 5; t++) begin
                for (int s = 0; s < 4; s++) begin
                    run_frame(fid, t, (s == 0) ? 64 : (s == 1) ? 1 : (s == 2) ? 3 : 8,
                              (s == 2), (fid % 2 == 1));
                    fid++;
                end
            end
            // R5: oversize split into many tiny segments
            run_frame(fid, 3 * MAXF, 2, 1'b1, 1'b0);
            fid++;
            // R8: saturation beyond 16 bits
            run_frame(fid, 70000, 40000, 1'b0, 1'b0);
            fid++;
            // frame after saturation starts from zero (R4)
            run_frame(fid, MAXF, 7, 1'b0, 1'b1);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule